// File: doc/BRIEF.md
# Synchronous Burst Address Counter

This block is the address unit of one port of a synchronous memory. On every rising clock edge it either clears its internal address to zero, loads an address from the external bus, advances the address by one, or keeps it. Three active-low controls pick the action: a counter clear, an address strobe and a count enable. The clear always wins, the strobe comes next, and the count enable acts only when neither of the others is asserted. A memory array placed behind the block takes the internal address directly, so long bursts need only one external address.

A fourth active-low control selects readback. When it is sampled low, the block drives the current internal address onto its readback data output, zero-extended to the data width, and raises an output-enable flag. A bus driver outside the block uses that flag to put the counter value on the shared data lines in place of memory data. When readback is not selected, the flag is low, which models the high-impedance state.

A clear takes effect in the same edge as any other action would. No idle cycle is inserted, so a read or write can use the cleared address in the following cycle.

Top module: `burst_addr_unit`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next address is 0 and the readback enable is 0.
- R2: When `clear_n` is sampled low, the next address is 0 whatever `strobe_n`, `step_en_n` and `ext_addr_i` hold.
- R3: When `clear_n` is high and `strobe_n` is low, the next address equals the sampled `ext_addr_i`, whatever `step_en_n` holds.
- R4: When `clear_n` and `strobe_n` are high and `step_en_n` is low, the next address is the current address plus one, and `ext_addr_i` has no effect.
- R5: Advancing from the all-ones address gives address 0.
- R6: When `clear_n`, `strobe_n` and `step_en_n` are all high, the address keeps its value and `ext_addr_i` has no effect.
- R7: When `readback_n` is sampled low, after that edge `readback_oe_o` is 1 and `readback_data_o` equals the address after that edge, zero-extended with the address in bits ADDR_W-1 down to 0.
- R8: When `readback_n` is sampled high, after that edge `readback_oe_o` is 0 and `readback_data_o` is all zeros.
- R9: A clear costs no cycle: a clear followed at the very next edge by an advance gives address 1, and a clear followed by a load gives the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr_i | input | ADDR_W | External address to load |
| strobe_n | input | 1 | Address strobe, active low: load `ext_addr_i` |
| step_en_n | input | 1 | Count enable, active low: advance by one |
| clear_n | input | 1 | Counter clear, active low: highest priority |
| readback_n | input | 1 | Readback select, active low |
| addr_o | output | ADDR_W | Internal address to the memory array |
| readback_data_o | output | DATA_W | Zero-extended counter value for the data bus |
| readback_oe_o | output | 1 | Drive enable for the readback value; 0 stands for high impedance |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 8. At this size every one of the 16 start addresses can be combined with all eight control patterns and both readback settings, so the priority order, the increment past 15 back to 0, and the zero upper bits of the readback value are all reached in one sweep. Explicit sequences then cover the reset state and a clear directly followed by an advance or a load.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } addr_op_e;

    typedef struct packed {
        logic clear_n;
        logic strobe_n;
        logic step_en_n;
    } ctl_pins_t;

    // Fixed priority: clear, then strobe, then count enable.
    function automatic addr_op_e pick_op(input ctl_pins_t c);
        if (!c.clear_n)
            return OP_CLEAR;
        else if (!c.strobe_n)
            return OP_LOAD;
        else if (!c.step_en_n)
            return OP_STEP;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
    import burst_addr_pkg::*;
(
    input  ctl_pins_t ctl_i,
    output addr_op_e  op_o
);

    always_comb begin
        op_o = pick_op(ctl_i);
    end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  addr_op_e          op_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        unique case (op_i)
            OP_CLEAR: addr_d = '0;
            OP_LOAD:  addr_d = ext_addr_i;
            OP_STEP:  addr_d = addr_q + ONE;
            default:  addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_STEP && addr_q == '1) |=> (addr_q == '0)); // R5

endmodule

// File: rtl/burst_readback.sv
module burst_readback #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              readback_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              oe_o
);

    logic              sel_q;
    logic [DATA_W-1:0] wide;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= 1'b0;
        else
            sel_q <= ~readback_n;
    end

    always_comb begin
        wide = '0;
        wide[ADDR_W-1:0] = addr_i;
    end

    assign oe_o   = sel_q;
    assign data_o = sel_q ? wide : '0;

    AST_RB_OFF: assert property (@(posedge clk) disable iff (rst)
        readback_n |=> (!oe_o && data_o == '0)); // R8

    AST_RB_ON: assert property (@(posedge clk) disable iff (rst)
        !readback_n |=> (oe_o && data_o[ADDR_W-1:0] == addr_i)); // R7

endmodule

// File: rtl/burst_addr_unit.sv
module burst_addr_unit
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr_i,
    input  logic              strobe_n,
    input  logic              step_en_n,
    input  logic              clear_n,
    input  logic              readback_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] readback_data_o,
    output logic              readback_oe_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    ctl_pins_t ctl;
    addr_op_e  op;

    assign ctl = '{clear_n: clear_n, strobe_n: strobe_n, step_en_n: step_en_n};

    burst_op_decode u_decode (
        .ctl_i (ctl),
        .op_o  (op)
    );

    burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op),
        .ext_addr_i (ext_addr_i),
        .addr_o     (addr_o)
    );

    burst_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rb (
        .clk        (clk),
        .rst        (rst),
        .readback_n (readback_n),
        .addr_i     (addr_o),
        .data_o     (readback_data_o),
        .oe_o       (readback_oe_o)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (addr_o == '0 && !readback_oe_o)); // R1

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> (addr_o == '0)); // R2

    AST_LOAD_EXT: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !strobe_n) |=> (addr_o == $past(ext_addr_i))); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (clear_n && strobe_n && !step_en_n) |=> (addr_o == $past(addr_o) + ONE)); // R4

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (clear_n && strobe_n && step_en_n) |=> $stable(addr_o)); // R6

endmodule

// File: tb/tb_burst_addr_unit.sv
module tb_burst_addr_unit;

    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] ext_addr_i;
    logic          strobe_n, step_en_n, clear_n, readback_n;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] readback_data_o;
    logic          readback_oe_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    burst_addr_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk             (clk),
        .rst             (rst),
        .ext_addr_i      (ext_addr_i),
        .strobe_n        (strobe_n),
        .step_en_n       (step_en_n),
        .clear_n         (clear_n),
        .readback_n      (readback_n),
        .addr_o          (addr_o),
        .readback_data_o (readback_data_o),
        .readback_oe_o   (readback_oe_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic cycle(input logic c_n, input logic s_n, input logic e_n,
                         input logic r_n, input logic [AW-1:0] ext);
        clear_n    = c_n;
        strobe_n   = s_n;
        step_en_n  = e_n;
        readback_n = r_n;
        ext_addr_i = ext;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string op_tag(input int ctl);
        if ((ctl & 4) == 0)      return "R2";
        else if ((ctl & 2) == 0) return "R3";
        else if ((ctl & 1) == 0) return "R4";
        else                     return "R6";
    endfunction

    initial begin
        rst = 1'b1;
        clear_n = 1'b1; strobe_n = 1'b1; step_en_n = 1'b1; readback_n = 1'b1;
        ext_addr_i = 4'd9;
        @(negedge clk);
        @(negedge clk);
        check("R1 addr after reset", int'(addr_o), 0);
        check("R1 oe after reset", int'(readback_oe_o), 0);
        rst = 1'b0;

        // Sweep: every start value, every control pattern, both readback settings.
        for (int start = 0; start < 16; start++) begin
            for (int ctl = 0; ctl < 8; ctl++) begin
                for (int rb = 0; rb < 2; rb++) begin
                    int ext;
                    int exp_addr;
                    ext = (start * 5 + 3 + ctl) % 16;
                    cycle(1'b1, 1'b0, 1'b1, 1'b1, AW'(start));
                    check("R3 load start", int'(addr_o), start);
                    cycle(ctl[2], ctl[1], ctl[0], rb[0], AW'(ext));
                    if ((ctl & 4) == 0)      exp_addr = 0;
                    else if ((ctl & 2) == 0) exp_addr = ext;
                    else if ((ctl & 1) == 0) exp_addr = (start + 1) % 16;
                    else                     exp_addr = start;
                    if (start == 15 && ctl == 6)
                        check("R5 wrap from all ones", int'(addr_o), 0);
                    else
                        check(op_tag(ctl), int'(addr_o), exp_addr);
                    if (rb == 0) begin
                        check("R7 oe", int'(readback_oe_o), 1);
                        check("R7 data", int'(readback_data_o), exp_addr);
                    end else begin
                        check("R8 oe", int'(readback_oe_o), 0);
                        check("R8 data", int'(readback_data_o), 0);
                    end
                end
            end
        end

        // R9: clear immediately followed by an advance, then by a load.
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 4'd11);
        cycle(1'b0, 1'b1, 1'b0, 1'b1, 4'd7);
        check("R9 clear", int'(addr_o), 0);
        cycle(1'b1, 1'b1, 1'b0, 1'b1, 4'd7);
        check("R9 advance after clear", int'(addr_o), 1);
        cycle(1'b0, 1'b0, 1'b0, 1'b1, 4'd7);
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 4'd13);
        check("R9 load after clear", int'(addr_o), 13);
        check("R7 readback after load", int'(readback_data_o), 13);

        // R1: reset mid-run returns to zero with readback off.
        rst = 1'b1;
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 4'd2);
        check("R1 addr after late reset", int'(addr_o), 0);
        check("R1 oe after late reset", int'(readback_oe_o), 0);
        rst = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule